// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

The block gathers a bank of asynchronous interrupt lines into a single request for a parent controller. Every line has its own trigger mode: high level, low level, rising edge or falling edge. Two per-line configuration bits choose the mode, one for the sense of the line and one for edge versus level. Each input is synchronized. In edge mode the selected transition is latched into a sticky status bit. In level mode the status bit shows the active sense of the synchronized input.

Software reaches the block over a small synchronous register bus. The bus has a byte address, a write strobe, write data and registered read data. Software reads the raw status and services bits from the lowest index up. It acknowledges them by writing ones to a clear location. It can raise any line itself through a set location. The enable mask is applied only where the status feeds the combined output, so status reads stay unmasked.

Top module: `trigger_intc`

## Requirements
- R1: After reset the enable, polarity and edge-select registers read 0, every latched status bit is clear and `irq_o` is low. With all inputs low, status therefore reads all ones, because every line is in level-low mode.
- R2: Byte offsets: status 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10, edge-select 0x14. Read data appears on the clock edge after the address is presented. Reading set, clear or any other offset returns 0.
- R3: Per-bit mode encoding, written as (edge, polarity): (0,1) is level-high, (0,0) is level-low, (1,1) is rising edge and (1,0) is falling edge.
- R4: In level mode a status bit equals the input in its active sense. A clear write has no lasting effect while that input is still active.
- R5: In edge mode a status bit sets on the selected transition and holds until a 1 is written to that bit of the clear register. Zeros written to clear leave status unchanged.
- R6: Writing 1 to a bit of the set register makes that status bit 1 on the next cycle, in either mode, until it is cleared.
- R7: Status is never masked. `irq_o` is a register holding the OR of (status AND enable) from the previous cycle. For a level-mode input that changes before clock edge k, `irq_o` rises after edge k+2.
- R8: A write to the polarity or edge-select register while the inputs are steady latches no status bit.
- R9: Writes to the status offset change no register and no status bit.
- R10: Each input passes through a two-flop synchronizer before any trigger logic sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Asynchronous interrupt lines |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Registered read data |
| irq_o | output | 1 | Combined interrupt request to the parent |

## Verification
A corrupted latched status bit shows up on the next status read. If that line is enabled, it also shows on `irq_o` one cycle after the corruption. A wrong synchronizer depth or a wrong edge-detect register moves the `irq_o` rising edge away from the exact edge that R7 names, so the timing is checked on a single cycle. The per-line sweep enables one line at a time. A line whose trigger, enable or clear wiring is swapped with another therefore gives the wrong request or status within a few cycles of its stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_ENABLE = 'h04;
  localparam int OFF_SET    = 'h08;
  localparam int OFF_CLEAR  = 'h0C;
  localparam int OFF_POL    = 'h10;
  localparam int OFF_EDGE   = 'h14;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'b00,
    TRIG_LEVEL_HIGH = 2'b01,
    TRIG_FALL       = 2'b10,
    TRIG_RISE       = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/intc_trigger.sv
module intc_trigger
  import intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] sync_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] edge_i,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  for (genvar b = 0; b < N_SRC; b++) begin : g_line
    trig_mode_e mode;
    logic       act_now;
    logic       act_prev;
    logic       hit;

    assign mode = trig_mode_e'({edge_i[b], pol_i[b]});

    // Both samples go through the current sense, so a sense change alone is no edge.
    assign act_now  = pol_i[b] ? sync_i[b] : ~sync_i[b];
    assign act_prev = pol_i[b] ? prev_q[b] : ~prev_q[b];

    always_comb begin
      case (mode)
        TRIG_RISE, TRIG_FALL: hit = act_now & ~act_prev;
        default:              hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) latch_q[b] <= 1'b0;
      else     latch_q[b] <= (latch_q[b] & ~clr_i[b]) | hit | set_i[b];
    end

    assign status_o[b] = latch_q[b] | (~edge_i[b] & act_now);
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  edge_o,
  output logic [N_SRC-1:0]  set_o,
  output logic [N_SRC-1:0]  clr_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFF_POL);
  localparam logic [ADDR_W-1:0] A_EDGE   = ADDR_W'(OFF_EDGE);

  assign set_o = (wr_i && addr_i == A_SET)   ? wdata_i : '0;
  assign clr_o = (wr_i && addr_i == A_CLEAR) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      pol_o  <= '0;
      edge_o <= '0;
    end else if (wr_i) begin
      if (addr_i == A_ENABLE) en_o   <= wdata_i;
      if (addr_i == A_POL)    pol_o  <= wdata_i;
      if (addr_i == A_EDGE)   edge_o <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      case (addr_i)
        A_STATUS: rdata_o <= status_i;
        A_ENABLE: rdata_o <= en_o;
        A_POL:    rdata_o <= pol_o;
        A_EDGE:   rdata_o <= edge_o;
        default:  rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/trigger_intc.sv
module trigger_intc #(
  parameter int N_SRC       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] sync_w;
  logic [N_SRC-1:0] status_w;
  logic [N_SRC-1:0] en_w;
  logic [N_SRC-1:0] pol_w;
  logic [N_SRC-1:0] edge_w;
  logic [N_SRC-1:0] set_w;
  logic [N_SRC-1:0] clr_w;

  intc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (sync_w)
  );

  intc_trigger #(.N_SRC(N_SRC)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .sync_i   (sync_w),
    .pol_i    (pol_w),
    .edge_i   (edge_w),
    .set_i    (set_w),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  intc_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .wdata_i  (bus_wdata_i),
    .status_i (status_w),
    .rdata_o  (bus_rdata_o),
    .en_o     (en_w),
    .pol_o    (pol_w),
    .edge_o   (edge_w),
    .set_o    (set_w),
    .clr_o    (clr_w)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_w & en_w);
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic [N_SRC-1:0]  wdata,
  input logic [N_SRC-1:0]  rdata,
  input logic              irq,
  input logic [N_SRC-1:0]  status,
  input logic [N_SRC-1:0]  en,
  input logic [N_SRC-1:0]  pol,
  input logic [N_SRC-1:0]  edge_sel
);
  // R1: the request is low on the cycle after any reset cycle
  a_r1_irq_reset: assert property (@(posedge clk) $past(rst) |-> !irq);

  // R7: the request is the masked OR of the previous cycle
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(|(status & en)));

  // R6: a set write shows every written bit in status next cycle
  a_r6_set_visible: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr && addr == ADDR_W'(OFF_SET)))
      |-> (status & $past(wdata)) == $past(wdata));

  // R9: a write to the status offset leaves configuration unchanged
  a_r9_status_wr_ignored: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr && addr == ADDR_W'(OFF_STATUS)))
      |-> ($stable(en) && $stable(pol) && $stable(edge_sel)));

  // R2: an enable read returns the register one cycle later
  a_r2_enable_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!wr && addr == ADDR_W'(OFF_ENABLE)))
      |-> rdata == $past(en));
endmodule

bind trigger_intc intc_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (bus_addr_i),
  .wr       (bus_wr_i),
  .wdata    (bus_wdata_i),
  .rdata    (bus_rdata_o),
  .irq      (irq_o),
  .status   (status_w),
  .en       (en_w),
  .pol      (pol_w),
  .edge_sel (edge_w)
);

// File: tb/trigger_intc_test.sv
`timescale 1ns/1ps
module trigger_intc_test;
  localparam int N  = 32;
  localparam int AW = 5;
  localparam logic [AW-1:0] O_ST  = 5'h00;
  localparam logic [AW-1:0] O_EN  = 5'h04;
  localparam logic [AW-1:0] O_SET = 5'h08;
  localparam logic [AW-1:0] O_CLR = 5'h0C;
  localparam logic [AW-1:0] O_POL = 5'h10;
  localparam logic [AW-1:0] O_EDG = 5'h14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  trigger_intc uut (
    .clk         (clk),
    .rst         (rst),
    .src_i       (src),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 5'h1C;
  endtask

  task automatic read_reg(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a; wr = 1'b0;
    @(posedge clk);
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] pa, pb, pc, pd, pm, ps;
    pa = 32'hA5C3_0F96; pb = 32'h0000_0F00; pc = 32'h0F0F_F0F0;
    pd = 32'h00FF_00FF; pm = 32'hFFFF_0000; ps = 32'h8000_0001;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    read_reg(O_EN, v);  check("R1 enable", v, '0);
    read_reg(O_POL, v); check("R1 polarity", v, '0);
    read_reg(O_EDG, v); check("R1 edge", v, '0);
    check("R1 irq", {31'd0, irq}, '0);
    read_reg(O_ST, v);  check("R1 status level-low view", v, '1);

    // R3 R4 level-high
    write_reg(O_POL, '1);
    src = pa; settle();
    read_reg(O_ST, v); check("R3 R4 level-high status", v, pa);
    write_reg(O_EN, pb); settle();
    check("R7 irq masked OR", {31'd0, irq}, {31'd0, |(pa & pb)});
    read_reg(O_ST, v); check("R7 status unmasked", v, pa);
    write_reg(O_CLR, '1); settle();
    read_reg(O_ST, v); check("R4 clear no lasting effect", v, pa);

    // R3 level-low
    write_reg(O_POL, '0); settle();
    read_reg(O_ST, v); check("R3 level-low status", v, ~pa);
    write_reg(O_EN, '0); settle();
    check("R7 irq off when masked", {31'd0, irq}, '0);

    // R8 config changes with steady inputs
    write_reg(O_POL, '1);
    write_reg(O_EDG, '1); settle();
    read_reg(O_ST, v); check("R8 edge switch no latch", v, '0);
    write_reg(O_POL, '0); settle();
    read_reg(O_ST, v); check("R8 polarity flip no latch", v, '0);
    write_reg(O_POL, '1); settle();
    read_reg(O_ST, v); check("R8 polarity restore no latch", v, '0);

    // R5 rising edge latch and write-one-to-clear
    src = pa | pc; settle();
    read_reg(O_ST, v); check("R5 rising latch", v, pc & ~pa);
    src = pa; settle();
    read_reg(O_ST, v); check("R5 holds after fall", v, pc & ~pa);
    write_reg(O_CLR, pm); settle();
    read_reg(O_ST, v); check("R5 partial clear", v, (pc & ~pa) & ~pm);
    write_reg(O_CLR, '0); settle();
    read_reg(O_ST, v); check("R5 zero clear no effect", v, (pc & ~pa) & ~pm);
    write_reg(O_CLR, '1); settle();
    read_reg(O_ST, v); check("R5 clear all", v, '0);

    // R3 falling edge
    write_reg(O_POL, '0); settle();
    src = pa & ~pd; settle();
    read_reg(O_ST, v); check("R3 falling latch", v, pa & pd);
    write_reg(O_CLR, '1); settle();

    // R6 software set
    write_reg(O_SET, ps); settle();
    read_reg(O_ST, v); check("R6 set status", v, ps);
    write_reg(O_EN, ps); settle();
    check("R6 set drives irq", {31'd0, irq}, 32'd1);
    write_reg(O_CLR, '1); settle();
    read_reg(O_ST, v); check("R6 cleared", v, '0);
    check("R6 irq drops", {31'd0, irq}, '0);

    // R9 status writes ignored
    write_reg(O_ST, '1); settle();
    read_reg(O_ST, v);  check("R9 status unchanged", v, '0);
    read_reg(O_EN, v);  check("R9 enable unchanged", v, ps);
    read_reg(O_POL, v); check("R9 polarity unchanged", v, '0);
    read_reg(O_EDG, v); check("R9 edge unchanged", v, '1);

    // R2 write-only and unused offsets
    read_reg(O_SET, v); check("R2 set reads zero", v, '0);
    read_reg(O_CLR, v); check("R2 clear reads zero", v, '0);
    read_reg(5'h18, v); check("R2 unused reads zero", v, '0);

    // R7 R10 latency in level-high mode
    write_reg(O_EDG, '0);
    write_reg(O_POL, '1);
    src = '0;
    write_reg(O_EN, 32'd1); settle();
    check("R7 irq idle", {31'd0, irq}, '0);
    @(negedge clk); src = 32'd1;
    @(posedge clk);
    @(posedge clk); #1 check("R10 irq low after two edges", {31'd0, irq}, '0);
    @(posedge clk); #1 check("R7 irq high at third edge", {31'd0, irq}, 32'd1);
    src = '0; settle();

    // R5 R7 per-line sweep in rising mode
    write_reg(O_EDG, '1);
    write_reg(O_CLR, '1); settle();
    for (int i = 0; i < N; i++) begin
      write_reg(O_EN, 32'd1 << i);
      src = 32'd1 << i; settle();
      read_reg(O_ST, v); check($sformatf("R5 sweep line %0d status", i), v, 32'd1 << i);
      check($sformatf("R7 sweep line %0d irq", i), {31'd0, irq}, 32'd1);
      src = '0;
      write_reg(O_CLR, 32'd1 << i); settle();
      check($sformatf("R5 sweep line %0d cleared", i), {31'd0, irq}, '0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule